// File: doc/BRIEF.md
# Highest-Priority Pending Interrupt Selector

This block looks at a parameterised set of interrupt sources and picks the single most urgent one that may be forwarded to one processor interface. Each source supplies a pending flag, an enable flag, a security flag and an 8-bit priority. Two global gates, one for Secure sources and one for Non-secure sources, decide which security class may take part at all.

The winner is reported as its interrupt ID, its stored priority and its security flag, together with a valid flag. When nothing qualifies, the ID output carries the reserved value 1023. A smaller priority number is more urgent. Only the upper six priority bits take part in the decision, and ties go to the lowest ID. The source index is the interrupt ID: 0 to 15 are software-generated, 16 to 31 are private peripheral and 32 upward are shared peripheral. The selection itself is a balanced comparison tree, and the result is held in one register stage.

Top module: `hpsel_top`

## Requirements
- R1: While reset is asserted, and until the first clock edge after its release, the outputs are winValid=0, winId=1023, winPrio=0 and winNs=0.
- R2: Among qualifying sources, the one with the numerically smallest priority value wins.
- R3: Priority bits [1:0] never affect the choice. The reported winPrio always has bits [1:0] equal to 0 and bits [7:2] equal to the winner's input bits [7:2].
- R4: When qualifying sources have equal stored priority, the one with the lowest ID wins.
- R5: A source whose enable bit is 0 is never selected, whatever its priority.
- R6: A source whose pending bit is 0 is never selected.
- R7: A source with nsVec bit 0 (Secure) qualifies only when secFwdEn=1. A source with nsVec bit 1 (Non-secure) qualifies only when nsFwdEn=1.
- R8: When no source qualifies, winValid=0, winId=1023, winPrio=0 and winNs=0.
- R9: The outputs are registered. They reflect the inputs sampled at the previous rising clock edge and do not change between edges.
- R10: winId equals the bit index of the winning source in the input vectors. The last index, NUM_SRC-1, can be selected.
- R11: winNs equals the nsVec bit of the winning source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pendVec | input | NUM_SRC | Per-source pending flags |
| enVec | input | NUM_SRC | Per-source enable flags |
| nsVec | input | NUM_SRC | Per-source security flag, 1 = Non-secure |
| prioFlat | input | NUM_SRC*8 | Per-source priority, source i in bits [8i+7:8i] |
| secFwdEn | input | 1 | Global forward enable for Secure sources |
| nsFwdEn | input | 1 | Global forward enable for Non-secure sources |
| winValid | output | 1 | A qualifying source was found |
| winId | output | 10 | Winning ID, or 1023 when there is none |
| winPrio | output | 8 | Winner's priority with bits [1:0] cleared |
| winNs | output | 1 | Winner's security flag |

## Verification
The assertions assume that every input is a defined 0 or 1 at each rising edge, and that reset is held long enough for the checker's registered copies of the previous inputs to be loaded before the first property is evaluated. The stimulus drives every input only on falling edges, applies reset for several cycles at the start and never leaves a bit undriven. Each test is one of two kinds. Directed cases set up ties, masked low priority bits, disabled and non-pending sources, and each combination of the two gates. Random cases fill all sources at once, with sparse enables, so that many sources compete for each result.

// File: rtl/hpsel_pkg.sv
package hpsel_pkg;
  localparam int ID_W    = 10;
  localparam int PRIO_W  = 8;
  localparam logic [ID_W-1:0] NONE_ID = 10'd1023;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic anyCand;
  } ctl_t;

  // One entry of the comparison tree
  typedef struct packed {
    logic              valid;
    logic [PRIO_W-1:0] prio;
    logic [ID_W-1:0]   id;
    logic              ns;
  } node_t;
endpackage

// File: rtl/hpsel_ctrl.sv
module hpsel_ctrl
  import hpsel_pkg::*;
#(
  parameter int NUM_SRC = 96
) (
  input  logic [NUM_SRC-1:0] pendVec,
  input  logic [NUM_SRC-1:0] enVec,
  input  logic [NUM_SRC-1:0] nsVec,
  input  logic               secFwdEn,
  input  logic               nsFwdEn,
  output logic [NUM_SRC-1:0] candMask,
  output ctl_t               ctl
);
  // A source takes part when it is pending, enabled and its class gate is open
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_qual
    assign candMask[i] = pendVec[i] & enVec[i] & (nsVec[i] ? nsFwdEn : secFwdEn);
  end

  always_comb begin
    ctl = '0;
    ctl.anyCand = |candMask;
  end
endmodule

// File: rtl/hpsel_tree.sv
module hpsel_tree
  import hpsel_pkg::*;
#(
  parameter int NUM_SRC   = 96,
  parameter int KEEP_BITS = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SRC-1:0]        candMask,
  input  logic [NUM_SRC-1:0]        nsVec,
  input  logic [NUM_SRC*PRIO_W-1:0] prioFlat,
  input  ctl_t                      ctl,
  output logic                      winValid,
  output logic [ID_W-1:0]           winId,
  output logic [PRIO_W-1:0]         winPrio,
  output logic                      winNs
);
  localparam int LEVELS = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int LEAVES = 1 << LEVELS;
  localparam int NODES  = 2 * LEAVES - 1;
  localparam logic [PRIO_W-1:0] PRIO_MASK = ~((PRIO_W'(1) << (PRIO_W - KEEP_BITS)) - PRIO_W'(1));

  node_t node [NODES];

  // The left child always covers lower IDs, so ties keep the left entry
  function automatic node_t pick(input node_t lft, input node_t rgt);
    if (lft.valid && (!rgt.valid || lft.prio <= rgt.prio)) return lft;
    return rgt;
  endfunction

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < NUM_SRC) begin : g_real
      assign node[LEAVES-1+j] = '{valid: candMask[j],
                                  prio:  prioFlat[j*PRIO_W +: PRIO_W] & PRIO_MASK,
                                  id:    ID_W'(j),
                                  ns:    nsVec[j]};
    end else begin : g_pad
      assign node[LEAVES-1+j] = '0;
    end
  end

  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_cmp
    assign node[k] = pick(node[2*k+1], node[2*k+2]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winValid <= 1'b0;
      winId    <= NONE_ID;
      winPrio  <= '0;
      winNs    <= 1'b0;
    end else if (ctl.anyCand) begin
      winValid <= 1'b1;
      winId    <= node[0].id;
      winPrio  <= node[0].prio;
      winNs    <= node[0].ns;
    end else begin
      winValid <= 1'b0;
      winId    <= NONE_ID;
      winPrio  <= '0;
      winNs    <= 1'b0;
    end
  end
endmodule

// File: rtl/hpsel_top.sv
module hpsel_top
  import hpsel_pkg::*;
#(
  parameter int NUM_SRC   = 96,
  parameter int KEEP_BITS = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SRC-1:0]        pendVec,
  input  logic [NUM_SRC-1:0]        enVec,
  input  logic [NUM_SRC-1:0]        nsVec,
  input  logic [NUM_SRC*PRIO_W-1:0] prioFlat,
  input  logic                      secFwdEn,
  input  logic                      nsFwdEn,
  output logic                      winValid,
  output logic [ID_W-1:0]           winId,
  output logic [PRIO_W-1:0]         winPrio,
  output logic                      winNs
);
  logic [NUM_SRC-1:0] candMask;
  ctl_t               ctl;

  hpsel_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .pendVec  (pendVec),
    .enVec    (enVec),
    .nsVec    (nsVec),
    .secFwdEn (secFwdEn),
    .nsFwdEn  (nsFwdEn),
    .candMask (candMask),
    .ctl      (ctl)
  );

  hpsel_tree #(.NUM_SRC(NUM_SRC), .KEEP_BITS(KEEP_BITS)) u_tree (
    .clk      (clk),
    .rstN     (rstN),
    .candMask (candMask),
    .nsVec    (nsVec),
    .prioFlat (prioFlat),
    .ctl      (ctl),
    .winValid (winValid),
    .winId    (winId),
    .winPrio  (winPrio),
    .winNs    (winNs)
  );
endmodule

// File: rtl/hpsel_chk.sv
module hpsel_chk #(
  parameter int NUM_SRC = 96
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] pendVec,
  input logic [NUM_SRC-1:0] enVec,
  input logic [NUM_SRC-1:0] nsVec,
  input logic               secFwdEn,
  input logic               nsFwdEn,
  input logic               winValid,
  input logic [9:0]         winId,
  input logic [7:0]         winPrio,
  input logic               winNs
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] prevPend, prevEn, prevNs;
  logic               prevSecEn, prevNsEn;
  logic [IDX_W-1:0]   idx;

  always_ff @(posedge clk) begin
    prevPend  <= pendVec;
    prevEn    <= enVec;
    prevNs    <= nsVec;
    prevSecEn <= secFwdEn;
    prevNsEn  <= nsFwdEn;
  end

  assign idx = winId[IDX_W-1:0];

  // R8: no winner means the reserved idle values
  p_idle_values_r8: assert property (@(posedge clk) disable iff (!rstN)
    !winValid |-> (winId == 10'd1023 && winPrio == 8'd0 && !winNs));

  // R10: a reported winner is a real source index
  p_id_in_range_r10: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> (winId < 10'(NUM_SRC)));

  // R5 and R6: the winner was pending and enabled at the previous edge
  p_winner_live_r5: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> (prevPend[idx] && prevEn[idx]));

  // R7: the winner's class gate was open
  p_class_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> (prevNs[idx] ? prevNsEn : prevSecEn));

  // R11: reported security flag follows the winner
  p_sec_flag_r11: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> (winNs == prevNs[idx]));

  // R3: the dropped priority bits always read as zero
  p_low_bits_r3: assert property (@(posedge clk) disable iff (!rstN)
    winPrio[1:0] == 2'b00);
endmodule

bind hpsel_top hpsel_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .pendVec  (pendVec),
  .enVec    (enVec),
  .nsVec    (nsVec),
  .secFwdEn (secFwdEn),
  .nsFwdEn  (nsFwdEn),
  .winValid (winValid),
  .winId    (winId),
  .winPrio  (winPrio),
  .winNs    (winNs)
);

// File: tb/sim_hpsel_top.sv
`timescale 1ns/1ps
module sim_hpsel_top;
  localparam int N = 96;

  logic           clk = 1'b0;
  logic           rstN;
  logic [N-1:0]   pendVec, enVec, nsVec;
  logic [N*8-1:0] prioFlat;
  logic           secFwdEn, nsFwdEn;
  logic           winValid;
  logic [9:0]     winId;
  logic [7:0]     winPrio;
  logic           winNs;

  int checks = 0;
  int fails  = 0;

  // Expected outputs for the inputs applied before the coming edge, and currently shown
  bit expV, curV;
  int expId, curId, expPr, curPr;
  bit expNs, curNs;

  always #2.5 clk = ~clk;

  hpsel_top #(.NUM_SRC(N)) u0 (
    .clk(clk), .rstN(rstN), .pendVec(pendVec), .enVec(enVec), .nsVec(nsVec),
    .prioFlat(prioFlat), .secFwdEn(secFwdEn), .nsFwdEn(nsFwdEn),
    .winValid(winValid), .winId(winId), .winPrio(winPrio), .winNs(winNs)
  );

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog expired: actual hung, expected completion");
    finishRun();
  end

  // Behavioural reference: scan IDs upward, replace only on a strictly smaller group value
  task automatic model();
    int bestP;
    expV = 0; expId = 1023; expPr = 0; expNs = 0; bestP = 1000;
    for (int i = 0; i < N; i++) begin
      int p;
      bit ok;
      ok = pendVec[i] && enVec[i] && (nsVec[i] ? nsFwdEn : secFwdEn);
      p  = prioFlat[i*8 +: 8] & 8'hFC;
      if (ok && p < bestP) begin
        bestP = p; expV = 1; expId = i; expPr = p; expNs = nsVec[i];
      end
    end
  endtask

  task automatic compare(string tag);
    checks++;
    if (winValid !== curV || winId !== 10'(curId) || winPrio !== 8'(curPr) || winNs !== curNs) begin
      fails++;
      $display("FAIL %s: actual v=%0b id=%0d pr=%0h ns=%0b expected v=%0b id=%0d pr=%0h ns=%0b",
               tag, winValid, winId, winPrio, winNs, curV, curId, curPr, curNs);
    end
  endtask

  // Inputs were set just after a falling edge; verify they have not yet shown, clock, verify result
  task automatic step(string tag);
    model();
    #1 compare("R9 hold");
    @(negedge clk);
    curV = expV; curId = expId; curPr = expPr; curNs = expNs;
    compare(tag);
  endtask

  task automatic clearAll();
    pendVec = '0; enVec = '0; nsVec = '0; prioFlat = '0;
    secFwdEn = 1'b1; nsFwdEn = 1'b1;
  endtask

  task automatic addSrc(int id, logic [7:0] pr, bit ns);
    pendVec[id] = 1'b1; enVec[id] = 1'b1; nsVec[id] = ns;
    prioFlat[id*8 +: 8] = pr;
  endtask

  initial begin
    rstN = 1'b0;
    clearAll();
    addSrc(3, 8'h10, 0);
    curV = 0; curId = 1023; curPr = 0; curNs = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 reset");
    rstN = 1'b1;
    clearAll();
    step("R8 empty");

    clearAll(); addSrc(5, 8'h40, 0);
    step("R2 single");
    clearAll(); addSrc(3, 8'h80, 0); addSrc(10, 8'h40, 0);
    step("R2 smaller value wins");
    clearAll(); addSrc(7, 8'h45, 0); addSrc(9, 8'h44, 0);
    step("R3 low bits ignored");
    clearAll(); addSrc(8, 8'h47, 1);
    step("R3 low bits cleared");
    clearAll(); addSrc(20, 8'h30, 0); addSrc(12, 8'h30, 1);
    step("R4 tie lowest id");
    clearAll(); addSrc(2, 8'h00, 0); enVec[2] = 1'b0; addSrc(50, 8'h10, 0);
    step("R5 disabled ignored");
    clearAll(); addSrc(4, 8'h00, 0); pendVec[4] = 1'b0; addSrc(60, 8'h20, 0);
    step("R6 not pending ignored");
    clearAll(); addSrc(1, 8'h00, 0); addSrc(40, 8'h20, 1); secFwdEn = 1'b0;
    step("R7 secure gated R11");
    nsFwdEn = 1'b0; secFwdEn = 1'b1;
    step("R7 nonsecure gated R11");
    secFwdEn = 1'b0;
    step("R8 both gates closed");
    clearAll(); addSrc(95, 8'hFC, 1);
    step("R10 last index");
    clearAll(); addSrc(95, 8'h08, 0); addSrc(0, 8'h08, 0);
    step("R10 ends tie R4");

    for (int c = 0; c < 600; c++) begin
      pendVec  = {$urandom, $urandom, $urandom};
      enVec    = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
      nsVec    = {$urandom, $urandom, $urandom};
      for (int i = 0; i < N; i++) prioFlat[i*8 +: 8] = 8'($urandom);
      secFwdEn = ($urandom % 4) != 0;
      nsFwdEn  = ($urandom % 4) != 0;
      step("R2 random");
    end

    rstN = 1'b0;
    #1;
    @(negedge clk);
    curV = 0; curId = 1023; curPr = 0; curNs = 0;
    compare("R1 reset again");
    finishRun();
  end
endmodule